// File: doc/BRIEF.md
# Converter Result Formatter and Conversion Control

This block is the digital back end of a 10-bit analog-to-digital converter. It starts conversions, accepts each raw 10-bit result when the converter pulses its done strobe, and stores the result as a high byte and a low byte. A 2-bit format field sets the layout of the two bytes. The four layouts are plain 8-bit truncation, right aligned, left aligned, and left aligned with the top bit inverted. The inverted layout gives a signed value measured from mid-scale.

Software reaches the block through a small register bus. The bus has a 2-bit address, read and write strobes, and 8-bit write and read data.

| Address | Register |
|---|---|
| 0 | Status/control. Bit 7 is the done flag and is read-only. Bit 1 selects continuous mode. Bit 0 is the enable. |
| 1 | Result high byte |
| 2 | Result low byte |
| 3 | Format field, in bits 1:0 |

In single mode the enable clears itself once a result has been accepted. In continuous mode results keep arriving, and each one overwrites the last, until software clears the enable. In the left-aligned formats the block uses a read interlock. Once the high byte has been read, new results are dropped until the low byte has been read.

Top module: `adc_result_regs`

## Requirements
- R1: After reset every register reads 0x00 and `conv_req` is low.
- R2: Format 2'b10 (left aligned): high = raw[9:2], low = {raw[1:0], 6'b0}.
- R3: Format 2'b01 (right aligned): high = {6'b0, raw[9:8]}, low = raw[7:0].
- R4: Format 2'b11 (signed, left aligned): high = {~raw[9], raw[8:2]}, low = {raw[1:0], 6'b0}.
- R5: Format 2'b00 (truncation): high = raw[9:2], low = 0x00.
- R6: Any accepted strobe sets the done flag (status bit 7). This holds even when the interlock drops the data. Two events clear the flag: any write to address 0, or a read of address 2. If an accepted strobe arrives in the same cycle as a clearing event, the strobe wins.
- R7: With status bits 1 and 0 both set, the enable stays set across strobes. Each stored result replaces the previous one, whether or not the previous one was read.
- R8: `conv_req` follows the enable bit (status bit 0). With continuous mode off, the enable clears after one accepted strobe. A strobe that arrives while the enable is low changes neither the flag nor the stored bytes.
- R9: In formats 2'b10 and 2'b11, a read of address 1 locks the stored bytes, and strobes that arrive while the lock is held are not stored. A read of address 2 releases the lock. In formats 2'b00 and 2'b01 a high-byte read does not lock.
- R10: Both bytes are fixed when the result is stored. A later change of the format field does not change the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_rd | input | 1 | Read strobe; read side effects take place at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| conv_req | output | 1 | Conversion request to the converter |
| conv_done | input | 1 | One-cycle strobe that marks the end of a conversion |
| conv_data | input | 10 | Raw result, valid while `conv_done` is high |

## Verification
The bench holds the high byte read and then sends a strobe before the low byte is read. A design with a missing or leaky interlock would return a low byte from the newer result, paired with a high byte from the older one. It also sends two results back to back in continuous mode, and sends a strobe while the enable is low. A broken enable path would either keep the stale result or accept a strobe it should drop. A format change between storage and readback catches a design that formats at read time, and the signed and truncation vectors expose an inverted bit or an unzeroed low byte.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

    localparam int unsigned RAW_W  = 10;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] A_HIGH   = 2'd1;
    localparam logic [ADDR_W-1:0] A_LOW    = 2'd2;
    localparam logic [ADDR_W-1:0] A_FORMAT = 2'd3;

    localparam int unsigned ST_EN   = 0;
    localparam int unsigned ST_CONT = 1;
    localparam int unsigned ST_FLAG = 7;

    typedef enum logic [1:0] {
        FMT_TRUNC8      = 2'b00,
        FMT_RIGHT       = 2'b01,
        FMT_LEFT        = 2'b10,
        FMT_LEFT_SIGNED = 2'b11
    } fmt_mode_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } fmt_pair_t;

    function automatic logic is_left_fmt(fmt_mode_e m);
        return (m == FMT_LEFT) || (m == FMT_LEFT_SIGNED);
    endfunction

    function automatic fmt_pair_t format_raw(fmt_mode_e m, logic [RAW_W-1:0] raw);
        fmt_pair_t p;
        case (m)
            FMT_TRUNC8: begin
                p.hi = raw[RAW_W-1:2];
                p.lo = '0;
            end
            FMT_RIGHT: begin
                p.hi = {6'b0, raw[RAW_W-1:BYTE_W]};
                p.lo = raw[BYTE_W-1:0];
            end
            FMT_LEFT: begin
                p.hi = raw[RAW_W-1:2];
                p.lo = {raw[1:0], 6'b0};
            end
            default: begin
                p.hi = {~raw[RAW_W-1], raw[RAW_W-2:2]};
                p.lo = {raw[1:0], 6'b0};
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/adc_fmt_unit.sv
module adc_fmt_unit
    import adc_fmt_pkg::*;
(
    input  fmt_mode_e          mode,
    input  logic [RAW_W-1:0]   raw,
    output fmt_pair_t          pair
);
    always_comb pair = format_raw(mode, raw);
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic stat_wr,
    input  logic wr_en,
    input  logic wr_cont,
    input  logic low_rd,
    input  logic done_in,
    output logic en,
    output logic cont,
    output logic flag,
    output logic accept
);
    logic en_q, cont_q, flag_q;

    assign accept = done_in & en_q;
    assign en     = en_q;
    assign cont   = cont_q;
    assign flag   = flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            cont_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (stat_wr) begin
                en_q   <= wr_en;
                cont_q <= wr_cont;
            end else if (accept && !cont_q) begin
                en_q <= 1'b0;
            end
            if (accept)
                flag_q <= 1'b1;
            else if (stat_wr || low_rd)
                flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_result_store.sv
module adc_result_store
    import adc_fmt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      accept,
    input  fmt_pair_t pair_in,
    input  logic      hi_rd,
    input  logic      lo_rd,
    input  logic      left_fmt,
    output fmt_pair_t pair_q,
    output logic      lock_q
);
    logic store;
    assign store = accept & ~lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '0;
            lock_q <= 1'b0;
        end else begin
            if (store)
                pair_q <= pair_in;
            if (lo_rd)
                lock_q <= 1'b0;
            else if (hi_rd && left_fmt)
                lock_q <= 1'b1;
        end
    end
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
    import adc_fmt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_rd,
    input  logic                   bus_wr,
    input  logic [BYTE_W-1:0]      bus_wdata,
    output logic [BYTE_W-1:0]      bus_rdata,
    output logic                   conv_req,
    input  logic                   conv_done,
    input  logic [RAW_W-1:0]       conv_data
);
    fmt_mode_e mode_q;
    fmt_pair_t fmt_now, pair_q;
    logic      en_q, cont_q, flag_q, accept, lock_q;
    logic      stat_wr, hi_rd, lo_rd;
    logic [BYTE_W-1:0] hi_q, lo_q;

    assign stat_wr = bus_wr && (bus_addr == A_STATUS);
    assign hi_rd   = bus_rd && (bus_addr == A_HIGH);
    assign lo_rd   = bus_rd && (bus_addr == A_LOW);

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= FMT_TRUNC8;
        else if (bus_wr && (bus_addr == A_FORMAT))
            mode_q <= fmt_mode_e'(bus_wdata[1:0]);
    end

    adc_conv_ctrl i_ctrl (
        .clk     (clk),
        .rst     (rst),
        .stat_wr (stat_wr),
        .wr_en   (bus_wdata[ST_EN]),
        .wr_cont (bus_wdata[ST_CONT]),
        .low_rd  (lo_rd),
        .done_in (conv_done),
        .en      (en_q),
        .cont    (cont_q),
        .flag    (flag_q),
        .accept  (accept)
    );

    adc_fmt_unit i_fmt (
        .mode (mode_q),
        .raw  (conv_data),
        .pair (fmt_now)
    );

    adc_result_store i_store (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .pair_in  (fmt_now),
        .hi_rd    (hi_rd),
        .lo_rd    (lo_rd),
        .left_fmt (is_left_fmt(mode_q)),
        .pair_q   (pair_q),
        .lock_q   (lock_q)
    );

    assign hi_q     = pair_q.hi;
    assign lo_q     = pair_q.lo;
    assign conv_req = en_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_STATUS: begin
                bus_rdata[ST_FLAG] = flag_q;
                bus_rdata[ST_CONT] = cont_q;
                bus_rdata[ST_EN]   = en_q;
            end
            A_HIGH:   bus_rdata = hi_q;
            A_LOW:    bus_rdata = lo_q;
            default:  bus_rdata[1:0] = mode_q;
        endcase
    end
endmodule

// File: rtl/adc_result_chk.sv
module adc_result_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] bus_addr,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic       conv_done,
    input logic       en,
    input logic       cont,
    input logic       flag,
    input logic       lock,
    input logic [7:0] hi,
    input logic [7:0] lo
);
    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (conv_done && en) |=> flag); // R6

    AST_LOW_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd2 && !(conv_done && en)) |=> !flag); // R6

    AST_SINGLE_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (conv_done && en && !cont && !(bus_wr && bus_addr == 2'd0)) |=> !en); // R8

    AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> ($stable(hi) && $stable(lo))); // R8

    AST_LOCK_HOLDS_DATA: assert property (@(posedge clk) disable iff (rst)
        lock |=> ($stable(hi) && $stable(lo))); // R9
endmodule

bind adc_result_regs adc_result_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .conv_done (conv_done),
    .en        (en_q),
    .cont      (cont_q),
    .flag      (flag_q),
    .lock      (lock_q),
    .hi        (hi_q),
    .lo        (lo_q)
);

// File: tb/test_adc_result_regs.sv
`timescale 1ns/1ps
module test_adc_result_regs;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       conv_req;
    logic       conv_done = 1'b0;
    logic [9:0] conv_data = '0;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    adc_result_regs i_adc_result_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .conv_req(conv_req), .conv_done(conv_done), .conv_data(conv_data)
    );

    // fields: [27:26] format, [25:16] raw, [15:8] high, [7:0] low
    localparam logic [27:0] VEC [8] = '{
        {2'b10, 10'h3FF, 8'hFF, 8'hC0},   // R2
        {2'b10, 10'h201, 8'h80, 8'h40},   // R2
        {2'b01, 10'h3A5, 8'h03, 8'hA5},   // R3
        {2'b01, 10'h102, 8'h01, 8'h02},   // R3
        {2'b11, 10'h200, 8'h00, 8'h00},   // R4
        {2'b11, 10'h1FF, 8'hFF, 8'hC0},   // R4
        {2'b00, 10'h2B7, 8'hAD, 8'h00},   // R5
        {2'b00, 10'h003, 8'h00, 8'h00}    // R5
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic conv(logic [9:0] d);
        @(negedge clk);
        conv_data = d; conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R1 reset read", v, 8'h00);
        end
        check("R1 conv_req", {7'b0, conv_req}, 8'h00);

        // table of formats, single mode
        for (int i = 0; i < 8; i++) begin
            wr(2'd3, {6'b0, VEC[i][27:26]});
            wr(2'd0, 8'h01);
            conv(VEC[i][25:16]);
            rd(2'd0, v);
            check("R6/R8 status after single", v, 8'h80);
            rd(2'd1, v);
            check("R2-5 high byte", v, VEC[i][15:8]);
            rd(2'd2, v);
            check("R2-5 low byte", v, VEC[i][7:0]);
            rd(2'd0, v);
            check("R6 flag cleared by low read", v, 8'h00);
        end

        // R8 strobe ignored while disabled
        wr(2'd3, 8'h01);
        conv(10'h155);
        rd(2'd0, v);
        check("R8 disabled strobe no flag", v, 8'h00);
        rd(2'd1, v);
        check("R8 disabled strobe no store", v, 8'h00);
        wr(2'd0, 8'h01);
        #1 check("R8 conv_req high", {7'b0, conv_req}, 8'h01);
        conv(10'h0F0);
        #1 check("R8 conv_req drops", {7'b0, conv_req}, 8'h00);

        // R7 continuous overwrite
        wr(2'd0, 8'h03);
        conv(10'h155);
        conv(10'h2AA);
        rd(2'd0, v);
        check("R7 enable stays in continuous", v, 8'h83);
        rd(2'd1, v);
        check("R7 newest high", v, 8'h02);
        rd(2'd2, v);
        check("R7 newest low", v, 8'hAA);

        // R6 status write clears flag
        conv(10'h001);
        wr(2'd0, 8'h03);
        rd(2'd0, v);
        check("R6 status write clears flag", v, 8'h03);

        // R9 interlock in left format
        wr(2'd3, 8'h02);
        conv(10'h3FF);
        rd(2'd1, v);
        check("R9 high before lock", v, 8'hFF);
        conv(10'h000);
        rd(2'd0, v);
        check("R9/R6 blocked strobe sets flag", v, 8'h83);
        rd(2'd2, v);
        check("R9 low kept while locked", v, 8'hC0);
        conv(10'h004);
        rd(2'd1, v);
        check("R9 stored after release high", v, 8'h01);
        rd(2'd2, v);
        check("R9 stored after release low", v, 8'h00);

        // R9 no lock in right format
        wr(2'd3, 8'h01);
        conv(10'h3FF);
        rd(2'd1, v);
        check("R9 right high", v, 8'h03);
        conv(10'h001);
        rd(2'd2, v);
        check("R9 right format not locked", v, 8'h01);

        // R10 bytes fixed at storage
        conv(10'h3A5);
        wr(2'd3, 8'h02);
        rd(2'd1, v);
        check("R10 high unchanged by format", v, 8'h03);
        rd(2'd2, v);
        check("R10 low unchanged by format", v, 8'hA5);
        wr(2'd0, 8'h00);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule